// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a synchronous host and a byte-wide asynchronous static RAM. The host presents one request at a time: an address, a direction flag and, for writes, a byte. The block turns that request into a timed bus cycle on the memory pins: address, active-low chip enable, output enable, write enable, and a data bus split into separate in, out and drive-enable signals. A one-cycle ready pulse marks completion. For reads, the captured byte is shown in that same cycle.

Every interval of the memory bus is a nanosecond parameter. The block converts each one to whole system clock cycles by ceiling division. The defaults describe a 70 ns part on a 5 ns clock. Writes use the write-enable-controlled style: chip enable and write enable fall together and rise together, and output enable stays high. After a read, the block waits a bus-release interval before it returns to idle, so that a following write cannot drive against the memory's outputs.

A protect input stands for a supply-fault warning. While it is high, no new bus cycle starts. A cycle already in progress finishes normally, so both strobes are back high before the supply drops.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, ce_n, oe_n and we_n are 1, dq_oe is 0 and ready is 0.
- R2: With SU = max(1, ceil(tAS/T)), the number of clock edges from the edge that accepts a request to the edge that raises ready is as follows. For a read it is SU + RACT + RHLD + TA. For a write it is SU + WACT + WHLD. RACT, WACT, RHLD, WHLD and TA are defined in the requirements below, and T is the clock period.
- R3: In a read, ce_n and oe_n are low together for exactly RACT = max(ceil(70/T), ceil(35/T)) cycles. dq_in is sampled at the edge that ends that window, and the sampled byte appears on rdata while ready is high.
- R4: In a write, ce_n and we_n are low together for exactly WACT = max(ceil(50/T), ceil(30/T), ceil(60/T) - SU) cycles, and oe_n stays 1 throughout.
- R5: In a write, dq_oe is 1 and dq_out holds the request byte for every cycle that we_n is low. Both stay that way for WHLD = max(1, ceil(5/T), ceil(70/T) - SU - WACT) cycles after we_n rises.
- R6: sram_addr equals the accepted request address from the cycle chip enable falls through the first cycle after it rises. It does not change while chip enable is low.
- R7: Two successive falling edges of ce_n are at least ceil(70/T) cycles apart. For reads, a hold of RHLD = max(1, ceil(70/T) - SU - RACT) cycles follows the access window.
- R8: dq_oe is never 1 while oe_n is 0. After oe_n rises, at least TA = ceil(25/T) cycles pass before dq_oe can rise.
- R9: ready is high for exactly one cycle per accepted request and is otherwise 0.
- R10: While protect is 1 in the idle state, a request is not accepted and is not remembered: ce_n stays 1 and no ready follows. A cycle accepted before protect rose runs to completion with its normal length.
- R11: A request presented in the same cycle that ready is high is accepted at that cycle's closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled in idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request byte address |
| req_wdata | input | 8 | Write byte |
| protect | input | 1 | Supply-fault lockout; blocks new cycles |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| sram_addr | output | 15 | Memory address bus |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| dq_in | input | 8 | Data bus as seen from the memory |
| dq_out | output | 8 | Data driven toward the memory |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
With the default 5 ns clock, ready is due 21 edges after an accepted read and 14 after an accepted write. The bench derives these counts from the nanosecond values by ceiling division and samples ready at every falling edge until it appears, so an early or late pulse is reported with its actual count. The memory model returns the inverted byte until chip enable has been low for the full access count. A capture made even one edge early therefore gives wrong data. Strobe widths, the data-hold tail, the gap from chip-enable fall to chip-enable fall and the bus-release gap are all counted at falling edges, and each is compared when its closing strobe edge is seen.

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl #(
  parameter int CLK_NS  = 5,
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OA_NS = 35,
  parameter int T_WP_NS = 50,
  parameter int T_DS_NS = 30,
  parameter int T_DH_NS = 5,
  parameter int T_AS_NS = 0,
  parameter int T_AW_NS = 60,
  parameter int T_TA_NS = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          protect,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SU_C   = imax(1, cyc(T_AS_NS));
  localparam int RACT_C = imax(1, imax(cyc(T_AA_NS), cyc(T_OA_NS)));
  localparam int WACT_C = imax(1, imax(imax(cyc(T_WP_NS), cyc(T_DS_NS)), cyc(T_AW_NS) - SU_C));
  localparam int RHLD_C = imax(1, cyc(T_RC_NS) - SU_C - RACT_C);
  localparam int WHLD_C = imax(imax(1, cyc(T_DH_NS)), cyc(T_RC_NS) - SU_C - WACT_C);
  localparam int TA_C   = cyc(T_TA_NS);
  localparam int MAX_C  = imax(imax(imax(SU_C, RACT_C), imax(WACT_C, RHLD_C)), imax(WHLD_C, TA_C));
  localparam int CW     = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACTIVE, S_HOLD, S_TURN} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          op_wr;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      op_wr     <= 1'b0;
      ready     <= 1'b0;
      rdata     <= '0;
      sram_addr <= '0;
      dq_out    <= '0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req && !protect) begin
            op_wr     <= req_wr;
            sram_addr <= req_addr;
            dq_out    <= req_wdata;
            cnt       <= CW'(SU_C - 1);
            state     <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (last) begin
            ce_n  <= 1'b0;
            state <= S_ACTIVE;
            if (op_wr) begin
              we_n  <= 1'b0;
              dq_oe <= 1'b1;
              cnt   <= CW'(WACT_C - 1);
            end else begin
              oe_n <= 1'b0;
              cnt  <= CW'(RACT_C - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ACTIVE: begin
          if (last) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            state <= S_HOLD;
            if (op_wr) begin
              cnt <= CW'(WHLD_C - 1);
            end else begin
              rdata <= dq_in;
              cnt   <= CW'(RHLD_C - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          if (last) begin
            dq_oe <= 1'b0;
            if (op_wr || TA_C == 0) begin
              ready <= 1'b1;
              state <= S_IDLE;
            end else begin
              cnt   <= CW'(TA_C - 1);
              state <= S_TURN;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TURN: begin
          if (last) begin
            ready <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst) !we_n |-> (!ce_n && oe_n)); // R4
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst) (dq_oe && $past(dq_oe)) |-> $stable(dq_out)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (!ce_n && $past(!ce_n)) |-> $stable(sram_addr)); // R6
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst) dq_oe |-> oe_n); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst) ready |=> !ready); // R9
  AST_PROTECT_IDLE: assert property (@(posedge clk) disable iff (rst) (state == S_IDLE && protect) |=> (state == S_IDLE && ce_n)); // R10

endmodule

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;
  localparam int TCK = 5;

  function automatic int cdiv(input int ns);
    return (ns + TCK - 1) / TCK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SU   = mx(1, cdiv(0));
  localparam int E_ACC  = cdiv(70);
  localparam int E_RACT = mx(cdiv(70), cdiv(35));
  localparam int E_WACT = mx(mx(cdiv(50), cdiv(30)), cdiv(60) - E_SU);
  localparam int E_RHLD = mx(1, cdiv(70) - E_SU - E_RACT);
  localparam int E_WHLD = mx(mx(1, cdiv(5)), cdiv(70) - E_SU - E_WACT);
  localparam int E_TA   = cdiv(25);
  localparam int E_RLAT = E_SU + E_RACT + E_RHLD + E_TA;
  localparam int E_WLAT = E_SU + E_WACT + E_WHLD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        protect = 1'b0;
  logic        ready;
  logic [7:0]  rdata;
  logic [14:0] sram_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  dq_out, dq_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(TCK/2.0) clk = ~clk;

  sram_cycle_ctrl i_sram_cycle_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .protect(protect), .ready(ready), .rdata(rdata),
    .sram_addr(sram_addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  logic [7:0]  mem [256];
  int          ce_cnt = 0, we_cnt = 0, oe_free = 1000, gap = 1000;
  logic [7:0]  last_wd = '0;
  logic        ce_q = 1'b1, dq_oe_q = 1'b0, wr_bad = 1'b0;
  logic [14:0] cur_addr = '0, fall_addr = '0;

  initial for (int j = 0; j < 256; j++) mem[j] = 8'(j) ^ 8'h33;

  assign dq_in = (!ce_n && !oe_n && we_n && ce_cnt >= E_ACC) ? mem[sram_addr[7:0]] : ~mem[sram_addr[7:0]];

  always @(negedge clk) begin
    if (!rst) begin
      if (dq_oe && !oe_n) chk(0, "R8 drive while oe low", 1, 0);
      if (dq_oe && !dq_oe_q) chk(oe_free >= E_TA, "R8 release gap", oe_free, E_TA);
      if (!ce_n && ce_q) begin
        chk(gap >= cdiv(70), "R7 ce fall spacing", gap, cdiv(70));
        gap = 0;
        fall_addr = sram_addr;
      end
      if (ce_n && !ce_q) begin
        chk(ce_cnt == (we_cnt > 0 ? E_WACT : E_RACT), we_cnt > 0 ? "R4 active width" : "R3 active width",
            ce_cnt, we_cnt > 0 ? E_WACT : E_RACT);
        chk(fall_addr == cur_addr && sram_addr == cur_addr, "R6 address held", int'(sram_addr), int'(cur_addr));
      end
      if (we_n && we_cnt > 0) begin
        chk(we_cnt == E_WACT, "R4 we width", we_cnt, E_WACT);
        chk(!wr_bad, "R4/R5 oe high and drive during we low", int'(wr_bad), 0);
        chk(dq_oe && dq_out == last_wd, "R5 data hold after we rise", int'(dq_out), int'(last_wd));
        mem[sram_addr[7:0]] = last_wd;
        we_cnt = 0;
        wr_bad = 1'b0;
      end
      if (!we_n) begin
        we_cnt++;
        if (we_cnt > 1 && dq_out != last_wd) wr_bad = 1'b1;
        last_wd = dq_out;
        if (!oe_n || !dq_oe) wr_bad = 1'b1;
      end
      if (!ce_n) ce_cnt++; else ce_cnt = 0;
      if (oe_n) oe_free++; else oe_free = 0;
      gap++;
      ce_q = ce_n;
      dq_oe_q = dq_oe;
    end
  end

  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                       input string tag, output logic [7:0] got);
    int k = 0;
    int lat = wr ? E_WLAT : E_RLAT;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; cur_addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    while (!ready && k < lat + 5) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
    chk(k == lat, tag, k, lat);
    got = rdata;
  endtask

  function automatic logic [14:0] addr_of(input int i);
    return {7'(i * 37 + 5), 8'(i * 3)};
  endfunction
  function automatic logic [7:0] dat_of(input int i);
    return 8'(i * 29 + 11) ^ 8'h5A;
  endfunction

  initial begin
    logic [7:0] got;
    int ce_low, rdy_seen;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && !ready, "R1 reset state", {ce_n, oe_n, we_n, dq_oe, ready}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && !ready, "R1 after release", {ce_n, oe_n, we_n, dq_oe, ready}, 5'b11100);

    for (int i = 0; i < 64; i++) do_op(1'b1, addr_of(i), dat_of(i), "R2 write latency", got);
    @(posedge clk); @(negedge clk);
    chk(ready == 1'b0, "R9 single pulse after write", int'(ready), 0);
    for (int i = 0; i < 64; i++) begin
      do_op(1'b0, addr_of(i), 8'h00, "R2 read latency", got);
      chk(got == dat_of(i), "R3 read data", int'(got), int'(dat_of(i)));
    end
    @(posedge clk); @(negedge clk);
    chk(ready == 1'b0, "R9 single pulse after read", int'(ready), 0);

    for (int i = 0; i < 32; i++) begin
      do_op(1'b1, addr_of(i), ~dat_of(i), "R11 back-to-back write", got);
      do_op(1'b0, addr_of(i), 8'h00, "R11 back-to-back read", got);
      chk(got == ~dat_of(i), "R3 read after write", int'(got), int'(~dat_of(i)));
    end

    protect = 1'b1;
    req = 1'b1; req_wr = 1'b1; req_addr = 15'h12F0; req_wdata = 8'h77;
    ce_low = 0; rdy_seen = 0;
    repeat (3) begin @(posedge clk); @(negedge clk); if (!ce_n) ce_low++; if (ready) rdy_seen++; end
    req = 1'b0;
    repeat (30) begin @(posedge clk); @(negedge clk); if (!ce_n) ce_low++; if (ready) rdy_seen++; end
    protect = 1'b0;
    repeat (10) begin @(posedge clk); @(negedge clk); if (!ce_n) ce_low++; if (ready) rdy_seen++; end
    chk(ce_low == 0, "R10 no cycle under protect", ce_low, 0);
    chk(rdy_seen == 0, "R10 request not remembered", rdy_seen, 0);
    do_op(1'b0, 15'h12F0, 8'h00, "R2 read latency", got);
    chk(got == (8'hF0 ^ 8'h33), "R10 blocked write left memory", int'(got), int'(8'hF0 ^ 8'h33));

    begin
      int k = 0;
      req = 1'b1; req_wr = 1'b1; req_addr = 15'h03F0; req_wdata = 8'hC6; cur_addr = 15'h03F0;
      @(posedge clk); @(negedge clk);
      req = 1'b0;
      while (!ready && k < E_WLAT + 5) begin
        @(posedge clk); @(negedge clk);
        k++;
        if (k == 3) protect = 1'b1;
      end
      chk(k == E_WLAT, "R10 in-flight cycle completes", k, E_WLAT);
      protect = 1'b0;
    end
    do_op(1'b0, 15'h03F0, 8'h00, "R2 read latency", got);
    chk(got == 8'hC6, "R10 in-flight write stored", int'(got), 8'hC6);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    #(TCK * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule